// File: doc/BRIEF.md
# Serial ADC Frame Sequencer

This block drives a 12-bit serial analog-to-digital converter over a chip-select, clock, command-in and result-out link. It runs on one system clock. It makes the converter clock with a divide-by-four phase counter and then repeats a fixed conversion slot of 28 converter-clock periods for as long as the host holds its active-low start input low. Each slot captures the host's 8-bit command word and opens the chip select. It waits two idle converter periods, shifts the command out MSB first on 8 clock pulses, and then reads 16 bits back from the converter, also MSB first.

Only the first 12 bits read back form the result. The block presents them as a zero-extended 16-bit word, together with the 3-bit channel field taken from the command word. A one-cycle `oe` pulse marks the result. The result and the channel stay put until the next slot ends. The slot is sequenced by a five-state machine. ST_IDLE waits for start. ST_LEAD holds the chip select low for 2 periods with the clock parked. ST_CMD runs 8 command periods and ST_READ runs 16 readback periods. ST_GAP holds the chip select high for 2 periods.

The transitions are as follows:
- ST_IDLE to ST_LEAD when `start_n` is low.
- ST_LEAD to ST_CMD after 2 periods.
- ST_CMD to ST_READ after 8 periods.
- ST_READ to ST_GAP after 16 periods. The result is published at this point.
- ST_GAP to ST_LEAD after 2 periods when `start_n` is low.
- ST_GAP to ST_IDLE after 2 periods when `start_n` is high.

Top module: `adc_frame_seq`

## Requirements
- R1: While `rst_n` is low (asynchronous), `cs_n`=1, `sclk`=0, `sdi`=0, `oe`=0, `data`=0 and `addr`=0.
- R2: `sclk` is high for exactly 2 system clocks and low for at least 2 between pulses. It gives exactly 24 rising edges per slot and is low whenever `cs_n` is high.
- R3: With `start_n` held low, `cs_n` falls once every 112 system clocks (28 converter periods) and stays low for 104 clocks each time.
- R4: No slot begins while `start_n` is high at a slot boundary or in idle. A slot already running when `start_n` rises completes, with its `oe` pulse and result, and the block then stays idle with `cs_n` high.
- R5: Over the 8 command clocks, `sdi` carries the captured command word MSB first. `sdi` changes only at the clock where `sclk` falls, holds steady while `sclk` is high, and is 0 whenever `cs_n` is high.
- R6: The first rising edge of `sclk` in a slot comes 10 system clocks after `cs_n` falls.
- R7: `data[11:0]` holds `sdo` as sampled at rising `sclk` edges 9 through 20 of the slot, with the first sample in bit 11. `data[15:12]` is always 0.
- R8: The value of `sdo` at rising edges 21 through 24 has no effect on `data`.
- R9: `oe` is high for exactly one clock, at the clock where `cs_n` rises at the end of readback. `data` and `addr` change only with `oe` and hold until the next pulse.
- R10: `addr` equals bits 6:4 of the command word captured for the slot that `oe` reports.
- R11: `ctrl_word` is captured at the clock edge where `cs_n` falls. Changes after that edge affect neither the command bits sent nor `addr` for that slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_n | input | 1 | Active-low run request from the host |
| ctrl_word | input | 8 | Command word for the next slot, channel field in bits 6:4 |
| sdo | input | 1 | Serial result bit from the converter |
| sclk | output | 1 | Converter clock, system clock divided by 4, gated to command and readback |
| cs_n | output | 1 | Active-low converter chip select |
| sdi | output | 1 | Serial command bit to the converter |
| data | output | 16 | Zero-extended 12-bit conversion result |
| addr | output | 3 | Channel field of the command that produced `data` |
| oe | output | 1 | One-clock result-valid pulse |

## Verification
The assertions watch the local signal rules on every cycle. They check that the clock stays parked and `sdi` stays quiet while the chip select is high, the two-clock high and low phases of `sclk`, and that `sdi` holds steady under a high clock. They also check that `oe` is a single pulse bound to the rising chip select, that the result and channel hold between pulses, and that the upper result bits stay at zero. The bench's converter model is needed for the slot-level behaviour. That model serves a different 16-bit readback pattern in each of 32 slots and varies the command word across all channels. The bench alone can show:
- the command bit order as the converter sees it;
- which 12 of the 16 readback bits land in `data`;
- the 112-clock slot period and the 10-clock lead;
- that late command changes are ignored;
- that the last slot completes after the start input is released.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    // Slot phases of the conversion sequencer.
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_LEAD = 3'd1,
        ST_CMD  = 3'd2,
        ST_READ = 3'd3,
        ST_GAP  = 3'd4
    } seq_state_e;

endpackage

// File: rtl/adc_clk_div.sv
// Phase counter that splits every converter period into DIV system clocks.
module adc_clk_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic rise_tick,
    output logic end_tick,
    output logic hi_nxt
);
    localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int HALF = DIV / 2;
    localparam logic [CW-1:0] LAST_V = CW'(DIV - 1);
    localparam logic [CW-1:0] PRE_RISE_V = CW'(HALF - 1);
    localparam logic [CW-1:0] HALF_V = CW'(HALF);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    always_comb begin
        if (!run) begin
            cnt_d = '0;
        end else if (cnt_q == LAST_V) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    // The edge after end_tick closes a period (converter clock falls).
    assign end_tick  = run && (cnt_q == LAST_V);
    // The edge after rise_tick is the converter rising edge.
    assign rise_tick = run && (cnt_q == PRE_RISE_V);
    // High phase of the converter clock in the next cycle.
    assign hi_nxt    = (cnt_d >= HALF_V);

endmodule

// File: rtl/adc_cmd_shifter.sv
// Parallel-load, MSB-first command serializer with channel field hold.
module adc_cmd_shifter #(
    parameter int W     = 8,
    parameter int F_LSB = 4,
    parameter int F_W   = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic           shift,
    input  logic           tick,
    input  logic [W-1:0]   word,
    output logic           sdi,
    output logic [F_W-1:0] field
);
    logic [W-1:0] sreg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            field  <= '0;
        end else if (load) begin
            sreg_q <= word;
            field  <= word[F_LSB +: F_W];
        end else if (shift) begin
            sreg_q <= {sreg_q[W-2:0], 1'b0};
        end
    end

    // Line updates only at period ends, i.e. when the converter clock falls.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdi <= 1'b0;
        end else if (shift) begin
            sdi <= sreg_q[W-1];
        end else if (tick) begin
            sdi <= 1'b0;
        end
    end

endmodule

// File: rtl/adc_rsp_capture.sv
// Deserializer for the valid result bits and the published result registers.
module adc_rsp_capture #(
    parameter int RES    = 12,
    parameter int DATA_W = 16,
    parameter int CH_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic              sdo,
    input  logic              done,
    input  logic [CH_W-1:0]   chan_in,
    output logic [DATA_W-1:0] data,
    output logic [CH_W-1:0]   addr,
    output logic              oe
);
    logic [RES-1:0] rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else if (sample) begin
            rx_q <= {rx_q[RES-2:0], sdo};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
            addr <= '0;
            oe   <= 1'b0;
        end else begin
            oe <= done;
            if (done) begin
                data <= DATA_W'(rx_q);
                addr <= chan_in;
            end
        end
    end

endmodule

// File: rtl/adc_frame_seq.sv
// Conversion-slot sequencer for a serial ADC link.
module adc_frame_seq
    import adc_seq_pkg::*;
#(
    parameter int DIV       = 4,
    parameter int SLOT_PER  = 28,
    parameter int LEAD_PER  = 2,
    parameter int CMD_BITS  = 8,
    parameter int READ_BITS = 16,
    parameter int RES_BITS  = 12,
    parameter int DATA_W    = 16,
    parameter int CH_LSB    = 4,
    parameter int CH_W      = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_n,
    input  logic [CMD_BITS-1:0] ctrl_word,
    input  logic                sdo,
    output logic                sclk,
    output logic                cs_n,
    output logic                sdi,
    output logic [DATA_W-1:0]   data,
    output logic [CH_W-1:0]     addr,
    output logic                oe
);
    localparam int GAP_PER = SLOT_PER - LEAD_PER - CMD_BITS - READ_BITS;
    localparam int PER_W   = $clog2(SLOT_PER);
    localparam logic [PER_W-1:0] LEAD_LAST = PER_W'(LEAD_PER - 1);
    localparam logic [PER_W-1:0] CMD_LAST  = PER_W'(CMD_BITS - 1);
    localparam logic [PER_W-1:0] READ_LAST = PER_W'(READ_BITS - 1);
    localparam logic [PER_W-1:0] GAP_LAST  = PER_W'(GAP_PER - 1);
    localparam logic [PER_W-1:0] RES_LIM   = PER_W'(RES_BITS);

    seq_state_e         state_q;
    seq_state_e         state_d;
    logic [PER_W-1:0]   per_q;
    logic [PER_W-1:0]   per_d;
    logic               run;
    logic               rise_tick;
    logic               end_tick;
    logic               hi_nxt;
    logic               load;
    logic               shift;
    logic               sample;
    logic               done;
    logic [CH_W-1:0]    chan;

    assign run = (state_q != ST_IDLE);

    adc_clk_div #(
        .DIV(DIV)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .rise_tick (rise_tick),
        .end_tick  (end_tick),
        .hi_nxt    (hi_nxt)
    );

    // Next-state logic: phases advance only at converter period ends.
    always_comb begin
        state_d = state_q;
        per_d   = per_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!start_n) begin
                    state_d = ST_LEAD;
                    per_d   = '0;
                end
            end
            ST_LEAD: begin
                if (end_tick) begin
                    if (per_q == LEAD_LAST) begin
                        state_d = ST_CMD;
                        per_d   = '0;
                    end else begin
                        per_d = per_q + 1'b1;
                    end
                end
            end
            ST_CMD: begin
                if (end_tick) begin
                    if (per_q == CMD_LAST) begin
                        state_d = ST_READ;
                        per_d   = '0;
                    end else begin
                        per_d = per_q + 1'b1;
                    end
                end
            end
            ST_READ: begin
                if (end_tick) begin
                    if (per_q == READ_LAST) begin
                        state_d = ST_GAP;
                        per_d   = '0;
                    end else begin
                        per_d = per_q + 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (end_tick) begin
                    if (per_q == GAP_LAST) begin
                        state_d = start_n ? ST_IDLE : ST_LEAD;
                        per_d   = '0;
                    end else begin
                        per_d = per_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = ST_IDLE;
                per_d   = '0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            per_q   <= '0;
        end else begin
            state_q <= state_d;
            per_q   <= per_d;
        end
    end

    // Registered link outputs, derived from the next state.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_n <= 1'b1;
            sclk <= 1'b0;
        end else begin
            cs_n <= !(state_d inside {ST_LEAD, ST_CMD, ST_READ});
            sclk <= (state_d inside {ST_CMD, ST_READ}) && hi_nxt;
        end
    end

    // Strobes for the datapath units.
    assign load   = (state_d == ST_LEAD) && (state_q != ST_LEAD);
    assign shift  = end_tick && (state_d == ST_CMD);
    assign sample = rise_tick && (state_q == ST_READ) && (per_q < RES_LIM);
    assign done   = end_tick && (state_q == ST_READ) && (per_q == READ_LAST);

    adc_cmd_shifter #(
        .W     (CMD_BITS),
        .F_LSB (CH_LSB),
        .F_W   (CH_W)
    ) u_cmd (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .shift (shift),
        .tick  (end_tick),
        .word  (ctrl_word),
        .sdi   (sdi),
        .field (chan)
    );

    adc_rsp_capture #(
        .RES    (RES_BITS),
        .DATA_W (DATA_W),
        .CH_W   (CH_W)
    ) u_rsp (
        .clk     (clk),
        .rst_n   (rst_n),
        .sample  (sample),
        .sdo     (sdo),
        .done    (done),
        .chan_in (chan),
        .data    (data),
        .addr    (addr),
        .oe      (oe)
    );

endmodule

// File: rtl/adc_frame_seq_chk.sv
// Port-level protocol checker for adc_frame_seq.
module adc_frame_seq_chk #(
    parameter int DATA_W   = 16,
    parameter int RES_BITS = 12,
    parameter int CH_W     = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sclk,
    input logic              cs_n,
    input logic              sdi,
    input logic              oe,
    input logic [DATA_W-1:0] data,
    input logic [CH_W-1:0]   addr
);

    p_clock_parked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    p_high_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |=> sclk);

    p_low_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |=> !sclk);

    p_sdi_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sdi);

    p_sdi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(sdi));

    p_pad_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (data >> RES_BITS) == '0);

    p_oe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        oe |=> !oe);

    p_oe_at_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> $rose(cs_n));

    p_release_has_oe_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> oe);

    p_data_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> $stable(data));

    p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> $stable(addr));

endmodule

bind adc_frame_seq adc_frame_seq_chk #(
    .DATA_W   (DATA_W),
    .RES_BITS (RES_BITS),
    .CH_W     (CH_W)
) i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .sclk  (sclk),
    .cs_n  (cs_n),
    .sdi   (sdi),
    .oe    (oe),
    .data  (data),
    .addr  (addr)
);

// File: tb/test_adc_frame_seq.sv
`timescale 1ns/1ps
module test_adc_frame_seq;

    localparam int NF = 32;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_n;
    logic [7:0]  ctrl_word;
    logic        sdo = 1'b0;
    logic        sclk;
    logic        cs_n;
    logic        sdi;
    logic [15:0] data;
    logic [2:0]  addr;
    logic        oe;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    adc_frame_seq i_adc_frame_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_n   (start_n),
        .ctrl_word (ctrl_word),
        .sdo       (sdo),
        .sclk      (sclk),
        .cs_n      (cs_n),
        .sdi       (sdi),
        .data      (data),
        .addr      (addr),
        .oe        (oe)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Converter model: result bits leave on falling edges after the command.
    logic [15:0] pattern = 16'h0;
    int          nfall = 0;
    always @(negedge sclk or posedge cs_n) begin
        if (cs_n) begin
            nfall <= 0;
            sdo   <= 1'b0;
        end else begin
            nfall <= nfall + 1;
            if (nfall >= 7 && nfall < 23) sdo <= pattern[15 - (nfall - 7)];
            else sdo <= 1'b0;
        end
    end

    // Converter model: command bits captured on rising edges.
    logic [7:0] cmd_cap  = 8'h0;
    logic [7:0] last_cmd = 8'h0;
    int         nrise = 0;
    int         last_nrise = 0;
    always @(posedge sclk or posedge cs_n) begin
        if (cs_n) begin
            if (nrise != 0) begin
                last_cmd   <= cmd_cap;
                last_nrise <= nrise;
            end
            nrise <= 0;
        end else begin
            if (nrise < 8) cmd_cap <= {cmd_cap[6:0], sdi};
            nrise <= nrise + 1;
        end
    end

    // Timing monitor, sampled at the falling system clock edge.
    int cyc = 0, fall_cyc = 0, fall_prev = 0, rise_cyc = 0, first_rise = 0;
    int nfr = 0, hi_run = 0, lo_run = 0;
    bit want_first = 0;
    logic prev_cs = 1'b1, prev_sclk = 1'b0;
    always @(negedge clk) begin
        cyc++;
        if (rst_n === 1'b1) begin
            if (prev_cs && !cs_n) begin
                fall_prev  = fall_cyc;
                fall_cyc   = cyc;
                want_first = 1;
                nfr++;
            end
            if (!prev_cs && cs_n) rise_cyc = cyc;
            if (!prev_sclk && sclk) begin
                if (want_first) begin
                    first_rise = cyc;
                    want_first = 0;
                end else begin
                    check(lo_run == 2, "R2 low phase", lo_run, 2);
                end
                hi_run = 0;
            end
            if (prev_sclk && !sclk) begin
                check(hi_run == 2, "R2 high phase", hi_run, 2);
                lo_run = 0;
            end
            if (sclk) hi_run++;
            else lo_run++;
        end
        prev_cs   = cs_n;
        prev_sclk = sclk;
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R4 watchdog: actual %0d expected %0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0]  c;
        logic [15:0] p;
        logic [15:0] exp_prev;
        logic [2:0]  addr_prev;
        rst_n     = 1'b0;
        start_n   = 1'b1;
        ctrl_word = 8'h00;
        exp_prev  = 16'h0;
        addr_prev = 3'h0;
        repeat (5) step();
        check(cs_n == 1'b1, "R1 cs_n", cs_n, 1);
        check(sclk == 1'b0, "R1 sclk", sclk, 0);
        check(sdi == 1'b0, "R1 sdi", sdi, 0);
        check(oe == 1'b0, "R1 oe", oe, 0);
        check(data == 16'h0, "R1 data", data, 0);
        check(addr == 3'h0, "R1 addr", addr, 0);
        rst_n = 1'b1;
        repeat (40) step();
        check(cs_n == 1'b1 && nfr == 0, "R4 idle while start_n high", nfr, 0);

        for (int i = 0; i < NF; i++) begin
            c = {1'b1, 3'(i), 1'b0, 1'(i / 8), 2'(i / 2)};
            if (i == 0) p = 16'hFFFF;
            else if (i == 1) p = 16'h000F;
            else p = 16'((i * 40503 + 4660) ^ (i << 5));
            if (p[3:0] == 4'h0) p[0] = 1'b1;
            ctrl_word = c;
            pattern   = p;
            if (i == 0) start_n = 1'b0;
            while (nfr < i + 1) step();
            if (i > 0) begin
                check(fall_cyc - fall_prev == 112, "R3 slot period", fall_cyc - fall_prev, 112);
                check(data == exp_prev, "R9 data held into next slot", data, exp_prev);
                check(addr == addr_prev, "R9 addr held into next slot", addr, addr_prev);
            end
            repeat (3) step();
            ctrl_word = ~c;
            if (i == NF - 1) start_n = 1'b1;
            while (oe !== 1'b1) step();
            check(data == {4'h0, p[15:4]}, "R7 R8 result bits", data, {4'h0, p[15:4]});
            check(addr == c[6:4], "R10 channel field", addr, c[6:4]);
            check(last_cmd == c, "R5 R11 command bits on sdi", last_cmd, c);
            check(last_nrise == 24, "R2 rising edges per slot", last_nrise, 24);
            check(rise_cyc - fall_cyc == 104, "R3 chip select low time", rise_cyc - fall_cyc, 104);
            check(first_rise - fall_cyc == 10, "R6 lead before first clock", first_rise - fall_cyc, 10);
            step();
            check(oe == 1'b0, "R9 oe single cycle", oe, 0);
            exp_prev  = {4'h0, p[15:4]};
            addr_prev = c[6:4];
        end

        repeat (300) step();
        check(nfr == NF, "R4 no slot after start_n release", nfr, NF);
        check(cs_n == 1'b1 && sclk == 1'b0, "R4 idle after last slot", {cs_n, sclk}, 2);
        check(data == exp_prev, "R9 data held in idle", data, exp_prev);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule